// File: doc/BRIEF.md
# Store-Buffered Direct-Mapped Cache Front End

This block is the memory-stage side of a direct-mapped data cache that finishes a store hit in one cycle. Each request carries an address, a load/store select, store data and per-byte enables. The tag lookup and the hit flag are combinational in the request cycle. A store that hits does not touch the data array in that cycle. Its word address, data and byte enables go into a single-entry pending-write register. That entry is written into the data array in the cycle when the next store does its own tag lookup. This way the array's one write port is never needed in the same cycle as a tag check for a later write.

A load compares its word address with the pending entry. Each byte lane whose enable is set in the pending entry comes from the buffered store data. The other lanes come from the array. Line fills arrive on a separate port that writes a whole line together with its tag. A fill has priority over any request in the same cycle. A fill also cancels a pending store aimed at the line it replaces. Miss handling and memory traffic sit outside the block.

Top module: `dwb_cache_front`

## Requirements
- R1: After reset every line is invalid, the pending entry is empty, and every request reports a miss until a fill arrives.
- R2: The address is split, from the least significant bit up, into a byte offset (ignored), a word-in-line offset, a line index and a tag. `rsp_hit` is high in the same cycle as a request that has no fill alongside it, whose line is valid and whose stored tag equals the address tag.
- R3: A load that hits returns the current word on `rsp_rdata` in the same cycle. A load that misses, and every store, returns zero.
- R4: A store hit is finished in its own cycle. A load to the same word in the very next cycle already returns the new data.
- R5: Bit i of `req_be` enables data bits 8i+7 to 8i. Only enabled bytes are changed. A load that matches the pending entry takes only those bytes from the buffer and the rest from the array.
- R6: At most one store is pending. It is written into the array on the next store request, whether that store hits or misses, so two stores in a row to the same word leave both sets of bytes merged.
- R7: A store that misses changes no cached data and no tag (no write allocate).
- R8: A fill writes all words of the line (word 0 in the least significant bits of `fill_line`), its tag, and sets the line valid. A pending store to the filled line is discarded, while a pending store to any other line is kept.
- R9: A request presented in the same cycle as a fill is ignored: no hit, zero read data, no change to the pending entry.
- R10: Loads never commit or clear the pending entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| rsp_hit | output | 1 | Tag hit for the current request |
| rsp_rdata | output | DATA_W | Load data (zero if not a load hit) |
| fill_valid | input | 1 | Line fill this cycle |
| fill_index | input | INDEX_W | Line being filled |
| fill_tag | input | TAG_W | Tag of the fill |
| fill_line | input | LINE_WORDS*DATA_W | Fill data, word 0 lowest |

## Verification
The patterns are chosen so that each one separates the buffer's view from the array's view. A store followed at once by a load to the same word passes only through the bypass. Two partial stores in a row to one word expose a commit that drops or reorders byte lanes. A fill landing on a line with a pending store, and a fill landing on a different line, show whether the pending entry is dropped only when it should be. Long random mixes with two competing tags per index, stores that miss, and requests blocked by fills are then compared cycle by cycle against a flat memory model of what each load should see.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
   typedef enum logic [1:0] {
      OP_IDLE    = 2'd0,
      OP_LOAD    = 2'd1,
      OP_STORE   = 2'd2,
      OP_BLOCKED = 2'd3
   } dwb_op_e;

   function automatic dwb_op_e decode_op(input logic valid, input logic store, input logic fill);
      if (!valid)     return OP_IDLE;
      else if (fill)  return OP_BLOCKED;
      else if (store) return OP_STORE;
      else            return OP_LOAD;
   endfunction
endpackage

// File: rtl/dwb_tag_store.sv
module dwb_tag_store #(
   parameter int NUM_LINES = 8,
   parameter int INDEX_W   = 3,
   parameter int TAG_W     = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] lk_index,
   input  logic [TAG_W-1:0]   lk_tag,
   output logic               lk_hit,
   input  logic               fill_en,
   input  logic [INDEX_W-1:0] fill_index,
   input  logic [TAG_W-1:0]   fill_tag
);
   logic [NUM_LINES-1:0] line_ok;
   logic [TAG_W-1:0]     line_tag [NUM_LINES];

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            line_ok[g]  <= 1'b0;
            line_tag[g] <= '0;
         end else if (fill_en && fill_index == INDEX_W'(g)) begin
            line_ok[g]  <= 1'b1;
            line_tag[g] <= fill_tag;
         end
      end
   end

   assign lk_hit = line_ok[lk_index] && (line_tag[lk_index] == lk_tag);

   AST_FILL_VALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> line_ok[$past(fill_index)]); // R8
endmodule

// File: rtl/dwb_data_array.sv
module dwb_data_array #(
   parameter int NUM_LINES  = 8,
   parameter int LINE_WORDS = 2,
   parameter int INDEX_W    = 3,
   parameter int OFFS_W     = 1,
   parameter int DATA_W     = 32,
   localparam int BE_W      = DATA_W / 8,
   localparam int NUM_WORDS = NUM_LINES * LINE_WORDS
) (
   input  logic                         clk,
   input  logic [INDEX_W-1:0]           rd_index,
   input  logic [OFFS_W-1:0]            rd_offs,
   output logic [DATA_W-1:0]            rd_word,
   input  logic                         fill_en,
   input  logic [INDEX_W-1:0]           fill_index,
   input  logic [LINE_WORDS*DATA_W-1:0] fill_line,
   input  logic                         wr_en,
   input  logic [INDEX_W-1:0]           wr_index,
   input  logic [OFFS_W-1:0]            wr_offs,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [BE_W-1:0]              wr_be
);
   logic [DATA_W-1:0] mem [NUM_WORDS];

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
         localparam int SLOT = l * LINE_WORDS + w;
         logic fill_hit, wr_hit;
         assign fill_hit = fill_en && fill_index == INDEX_W'(l);
         assign wr_hit   = wr_en && wr_index == INDEX_W'(l) && wr_offs == OFFS_W'(w);
         for (genvar b = 0; b < BE_W; b++) begin : g_lane
            always_ff @(posedge clk) begin
               if (fill_hit)
                  mem[SLOT][8*b +: 8] <= fill_line[w*DATA_W + 8*b +: 8];
               else if (wr_hit && wr_be[b])
                  mem[SLOT][8*b +: 8] <= wr_data[8*b +: 8];
            end
         end
      end
   end

   assign rd_word = mem[{rd_index, rd_offs}];
endmodule

// File: rtl/dwb_pending_reg.sv
module dwb_pending_reg #(
   parameter int WADDR_W = 10,
   parameter int DATA_W  = 32,
   localparam int BE_W   = DATA_W / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture_en,
   input  logic [WADDR_W-1:0] cap_waddr,
   input  logic [DATA_W-1:0]  cap_data,
   input  logic [BE_W-1:0]    cap_be,
   input  logic               commit_en,
   input  logic               drop_en,
   output logic               pend_valid,
   output logic [WADDR_W-1:0] pend_waddr,
   output logic [DATA_W-1:0]  pend_data,
   output logic [BE_W-1:0]    pend_be,
   input  logic [WADDR_W-1:0] lk_waddr,
   input  logic [DATA_W-1:0]  array_word,
   output logic [DATA_W-1:0]  merged_word
);
   logic match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_waddr <= '0;
         pend_data  <= '0;
         pend_be    <= '0;
      end else if (drop_en) begin
         pend_valid <= 1'b0;
      end else if (capture_en) begin
         pend_valid <= 1'b1;
         pend_waddr <= cap_waddr;
         pend_data  <= cap_data;
         pend_be    <= cap_be;
      end else if (commit_en) begin
         pend_valid <= 1'b0;
      end
   end

   assign match = pend_valid && (pend_waddr == lk_waddr);

   for (genvar b = 0; b < BE_W; b++) begin : g_merge
      assign merged_word[8*b +: 8] = (match && pend_be[b]) ? pend_data[8*b +: 8]
                                                           : array_word[8*b +: 8];
   end

   AST_DROP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      drop_en |=> !pend_valid); // R8
endmodule

// File: rtl/dwb_cache_front.sv
module dwb_cache_front #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int NUM_LINES  = 8,
   parameter int LINE_WORDS = 2,
   localparam int BE_W      = DATA_W / 8,
   localparam int BOFF_W    = $clog2(BE_W),
   localparam int OFFS_W    = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
   localparam int INDEX_W   = $clog2(NUM_LINES),
   localparam int TAG_W     = ADDR_W - INDEX_W - OFFS_W - BOFF_W,
   localparam int WADDR_W   = ADDR_W - BOFF_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic                         req_store,
   input  logic [ADDR_W-1:0]            req_addr,
   input  logic [DATA_W-1:0]            req_wdata,
   input  logic [BE_W-1:0]              req_be,
   output logic                         rsp_hit,
   output logic [DATA_W-1:0]            rsp_rdata,
   input  logic                         fill_valid,
   input  logic [INDEX_W-1:0]           fill_index,
   input  logic [TAG_W-1:0]             fill_tag,
   input  logic [LINE_WORDS*DATA_W-1:0] fill_line
);
   import dwb_pkg::*;

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if ((1 << INDEX_W) != NUM_LINES || LINE_WORDS < 2 || (1 << OFFS_W) != LINE_WORDS) begin : g_bad_geom
      $error("NUM_LINES and LINE_WORDS must be powers of two, LINE_WORDS >= 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for the chosen geometry");
   end

   dwb_op_e            op;
   logic [WADDR_W-1:0] req_waddr;
   logic [OFFS_W-1:0]  req_offs;
   logic [INDEX_W-1:0] req_index;
   logic [TAG_W-1:0]   req_tag;
   logic               tag_hit;
   logic               capture_en, commit_en, drop_en;
   logic               pend_valid;
   logic [WADDR_W-1:0] pend_waddr;
   logic [DATA_W-1:0]  pend_data;
   logic [BE_W-1:0]    pend_be;
   logic [DATA_W-1:0]  array_word, merged_word;

   assign op        = decode_op(req_valid, req_store, fill_valid);
   assign req_waddr = req_addr[ADDR_W-1:BOFF_W];
   assign req_offs  = req_waddr[OFFS_W-1:0];
   assign req_index = req_waddr[OFFS_W +: INDEX_W];
   assign req_tag   = req_waddr[WADDR_W-1 -: TAG_W];

   dwb_tag_store #(.NUM_LINES(NUM_LINES), .INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .lk_index(req_index), .lk_tag(req_tag), .lk_hit(tag_hit),
      .fill_en(fill_valid), .fill_index(fill_index), .fill_tag(fill_tag));

   assign capture_en = (op == OP_STORE) && tag_hit;
   assign commit_en  = (op == OP_STORE) && pend_valid;
   assign drop_en    = fill_valid && pend_valid && (pend_waddr[OFFS_W +: INDEX_W] == fill_index);

   dwb_data_array #(.NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .INDEX_W(INDEX_W),
                    .OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_data (
      .clk(clk),
      .rd_index(req_index), .rd_offs(req_offs), .rd_word(array_word),
      .fill_en(fill_valid), .fill_index(fill_index), .fill_line(fill_line),
      .wr_en(commit_en), .wr_index(pend_waddr[OFFS_W +: INDEX_W]),
      .wr_offs(pend_waddr[OFFS_W-1:0]), .wr_data(pend_data), .wr_be(pend_be));

   dwb_pending_reg #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .capture_en(capture_en), .cap_waddr(req_waddr), .cap_data(req_wdata), .cap_be(req_be),
      .commit_en(commit_en), .drop_en(drop_en),
      .pend_valid(pend_valid), .pend_waddr(pend_waddr), .pend_data(pend_data), .pend_be(pend_be),
      .lk_waddr(req_waddr), .array_word(array_word), .merged_word(merged_word));

   assign rsp_hit   = (op == OP_LOAD || op == OP_STORE) && tag_hit;
   assign rsp_rdata = (op == OP_LOAD && tag_hit) ? merged_word : '0;

   AST_STORE_HIT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store && !fill_valid && rsp_hit) |=> pend_valid); // R6
   AST_STORE_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store && !fill_valid && !rsp_hit) |=> !pend_valid); // R7
   AST_LOAD_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store && !fill_valid) |=> $stable(pend_valid)); // R10
   AST_FILL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> !rsp_hit); // R9
   AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_valid && commit_en)); // R9
endmodule

// File: tb/dwb_cache_front_test.sv
module dwb_cache_front_test;
   localparam int AW = 12, DW = 32, NL = 8, WPL = 2;
   localparam int BEW = DW / 8, IW = 3, OW = 1, TW = AW - IW - OW - 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_store = 0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [BEW-1:0] req_be = '0;
   logic rsp_hit;
   logic [DW-1:0] rsp_rdata;
   logic fill_valid = 0;
   logic [IW-1:0] fill_index = '0;
   logic [TW-1:0] fill_tag = '0;
   logic [WPL*DW-1:0] fill_line = '0;

   int checks = 0, fails = 0;
   bit done = 0;

   bit            m_valid [NL];
   logic [TW-1:0] m_tag   [NL];
   logic [DW-1:0] m_data  [NL][WPL];

   always #5 clk = ~clk;

   dwb_cache_front uut (.*);

   function automatic logic [AW-1:0] mk(input int tag, input int idx, input int off);
      return {TW'(tag), IW'(idx), OW'(off), 2'b00};
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input bit v, input bit st, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [BEW-1:0] be, input bit fv, input int fi, input int ft,
                       input logic [WPL*DW-1:0] fl, input string req);
      int idx, off, tg;
      bit exp_hit;
      logic [DW-1:0] exp_rd;
      @(negedge clk);
      req_valid = v; req_store = st; req_addr = a; req_wdata = d; req_be = be;
      fill_valid = fv; fill_index = IW'(fi); fill_tag = TW'(ft); fill_line = fl;
      tg  = int'(a[AW-1 -: TW]);
      idx = int'(a[2+OW +: IW]);
      off = int'(a[2 +: OW]);
      exp_hit = v && !fv && m_valid[idx] && m_tag[idx] == TW'(tg);
      exp_rd  = (exp_hit && !st) ? m_data[idx][off] : '0;
      #3;
      chk({req, " hit"}, DW'(rsp_hit), DW'(exp_hit));
      chk({req, " rdata"}, rsp_rdata, exp_rd);
      @(posedge clk);
      if (fv) begin
         m_valid[fi] = 1;
         m_tag[fi] = TW'(ft);
         for (int w = 0; w < WPL; w++) m_data[fi][w] = fl[w*DW +: DW];
      end else if (exp_hit && st) begin
         for (int b = 0; b < BEW; b++)
            if (be[b]) m_data[idx][off][8*b +: 8] = d[8*b +: 8];
      end
   endtask

   task automatic ld(input int t, input int i, input int o, input string req);
      step(1, 0, mk(t, i, o), '0, '0, 0, 0, 0, '0, req);
   endtask
   task automatic sto(input int t, input int i, input int o, input logic [DW-1:0] d,
                      input logic [BEW-1:0] be, input string req);
      step(1, 1, mk(t, i, o), d, be, 0, 0, 0, '0, req);
   endtask
   task automatic fil(input int i, input int t, input logic [WPL*DW-1:0] fl, input string req);
      step(0, 0, '0, '0, '0, 1, i, t, fl, req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NL; i++) begin
         m_valid[i] = 0; m_tag[i] = '0;
         for (int w = 0; w < WPL; w++) m_data[i][w] = '0;
      end
      repeat (2) @(posedge clk);
      #3 chk("R1 hit during reset", DW'(rsp_hit), 0);
      @(negedge clk); rst_n = 1;
      // R1: everything misses after reset
      ld(0, 0, 0, "R1 cold load");
      sto(0, 0, 0, 32'hAAAA5555, 4'hF, "R1 cold store");
      // R8 fills, R2/R3 lookups
      fil(0, 1, 64'h22222222_11111111, "R8 fill idx0");
      fil(1, 1, 64'h44444444_33333333, "R8 fill idx1");
      ld(1, 0, 0, "R3 load w0");
      ld(1, 0, 1, "R3 load w1");
      ld(2, 0, 0, "R2 tag mismatch");
      step(1, 0, mk(1, 0, 1) | 12'h3, '0, '0, 0, 0, 0, '0, "R2 byte offset ignored");
      // R4 back-to-back store then load
      sto(1, 0, 0, 32'hDEADBEEF, 4'hF, "R4 store hit");
      ld(1, 0, 0, "R4 bypass load");
      ld(1, 0, 1, "R10 other word while pending");
      ld(1, 0, 0, "R10 still pending");
      // R5 partial store, R6 consecutive stores merge
      sto(1, 0, 1, 32'hA1B2C3D4, 4'b0101, "R5 partial store");
      ld(1, 0, 1, "R5 merged bypass");
      sto(1, 0, 1, 32'h99887766, 4'b1010, "R6 second store same word");
      ld(1, 0, 1, "R6 both merged");
      ld(1, 0, 0, "R6 committed earlier word");
      // R7 store miss
      sto(2, 1, 0, 32'h0BADF00D, 4'hF, "R7 store miss");
      ld(1, 1, 0, "R7 line untouched");
      ld(2, 1, 0, "R7 no allocate");
      // R8 fill over pending line drops it
      sto(1, 1, 1, 32'hCAFEF00D, 4'hF, "R8 store to be dropped");
      fil(1, 1, 64'h66666666_55555555, "R8 refill same line");
      ld(1, 1, 1, "R8 fill data wins");
      sto(1, 1, 0, 32'h12345678, 4'h3, "R8 store after drop");
      ld(1, 1, 1, "R8 dropped store not committed");
      // R8 fill to another line keeps pending
      sto(1, 0, 0, 32'h0F0F0F0F, 4'hF, "R8 store kept");
      fil(2, 3, 64'h88888888_77777777, "R8 fill other line");
      ld(1, 0, 0, "R8 pending survives");
      ld(3, 2, 1, "R8 new line");
      sto(3, 2, 0, 32'h11112222, 4'h8, "R6 commit then capture");
      ld(1, 0, 0, "R6 committed value");
      // R9 request alongside fill
      step(1, 1, mk(1, 0, 0), 32'hFFFFFFFF, 4'hF, 1, 5, 2, 64'h1, "R9 blocked store");
      step(1, 0, mk(3, 2, 0), '0, '0, 1, 6, 2, 64'h2, "R9 blocked load");
      ld(1, 0, 0, "R9 store had no effect");
      ld(3, 2, 0, "R9 pending kept");
      // random mix against the model
      for (int n = 0; n < 4000; n++) begin
         int r = $urandom_range(0, 99);
         int t = $urandom_range(1, 2), i = $urandom_range(0, NL-1), o = $urandom_range(0, WPL-1);
         logic [WPL*DW-1:0] fl = {$urandom, $urandom};
         if (r < 8) fil(i, t, fl, "R8 random fill");
         else if (r < 12) step(1, $urandom_range(0, 1), mk(t, i, o), $urandom, BEW'($urandom),
                               1, i, t, fl, "R9 random blocked");
         else if (r < 50) sto(t, i, o, $urandom, BEW'($urandom), "R6 random store");
         else ld(t, i, o, "R5 random load");
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule